// File: doc/BRIEF.md
# TLB Way Degradation Controller

This block manages the health of a two-way set-associative translation buffer. It keeps track of which of the two ways may take part in lookups and refills. When the fault logic reports a failing way, the controller turns that way off and walks through every entry index of it so the buffer can clear those entries. It also raises a sticky error flag that software can read and clear.

The buffer is never shut down completely. If a fault names the only way still running, the controller brings back the way it turned off earlier and takes the named way out of service. So after any fault, exactly the named way is off and the other way is on.

Fault reports that arrive while a walk is running are held and never lost. A report for a way that is already waiting merges with it, and the way reported most recently is served last. While a walk is running, refills into either way are blocked.

Top module: `tlb_way_degrade`

## Requirements
- R1: After reset both ways are enabled, refills are allowed into both, no walk is busy and the error flag is clear.
- R2: A fault report naming way W (0 or 1) while the other way is enabled clears enable bit W at the next clock edge and leaves the other bit set. `way_active[W]` is 1 when way W is enabled.
- R3: A fault report naming the only enabled way re-enables the other way and disables the named way. At most one way is ever disabled, and the enable mask changes only on the edge where a walk starts.
- R4: The invalidate walk starts at the clock edge that accepts a fault. It keeps `inv_busy` high for exactly ENTRIES cycles, presents `inv_idx` 0 to ENTRIES-1 one per cycle in rising order, and holds `inv_way` at the disabled way.
- R5: `refill_allow` equals `way_active` when no walk is busy and is 2'b00 while a walk is busy.
- R6: The error flag is set on the edge where any walk starts, whatever the number of enabled ways before it, and stays set until it is cleared.
- R7: A pulse on `err_clr` clears the error flag at the next edge unless a walk starts on that same edge, in which case the flag stays set.
- R8: A fault report accepted while a walk is busy is held. Its walk starts on the edge right after the previous walk's last index, so `inv_busy` stays high with no gap.
- R9: With reports for both ways waiting, the way reported most recently is walked last. A repeated report of a way that is already waiting merges with it and adds no extra walk.
- R10: A fault report naming the way that is already disabled leaves the enable mask unchanged, runs a full walk of that way and sets the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_vld | input | 1 | One-cycle fault report strobe |
| fault_way | input | 1 | Way named by the fault report |
| err_clr | input | 1 | Software clear pulse for the error flag |
| way_active | output | 2 | Per-way lookup enable mask |
| refill_allow | output | 2 | Per-way refill permission mask |
| inv_busy | output | 1 | Invalidate walk in progress; entry write strobe |
| inv_way | output | 1 | Way being invalidated |
| inv_idx | output | $clog2(ENTRIES) | Entry index being invalidated |
| err_flag | output | 1 | Sticky restrainable-error flag |

## Verification
The bench covers several corner cases, each chosen because a specific mistake would show up there:
- A fault on the last enabled way: a design that shuts down instead of swapping would show both enable bits low.
- A fault on the way that is already off: a design that treats the report as a toggle would re-enable that way.
- Reports that land during a walk: a design that drops them would end with the wrong enable mask. A design that inserts an idle cycle between walks would break the unbroken busy run.
- A pending way reported again: a design that serves in first-arrival order, or does not merge, would give a wrong final mask or an extra ENTRIES cycles of busy.
- A clear pulse that lands on the edge where a walk starts: a design where the clear wins would lose the error report.

// File: rtl/tlb_wd_pkg.sv
package tlb_wd_pkg;
  localparam int NUM_WAYS = 2;

  typedef logic [NUM_WAYS-1:0] way_mask_t;

  // one-hot mask for a single way index
  function automatic way_mask_t way_bit(input logic w);
    way_mask_t m;
    m    = '0;
    m[w] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/tlb_wd_rst_sync.sv
module tlb_wd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tlb_wd_fault_hold.sv
module tlb_wd_fault_hold
  import tlb_wd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fault_vld,
  input  logic fault_way,
  input  logic take,
  output logic pend_any,
  output logic serve_way
);
  way_mask_t pend_q, pend_d, pend_m;
  logic      last_q, last_d;
  logic      upd_en;

  always_comb begin
    pend_m    = pend_q | (fault_vld ? way_bit(fault_way) : '0);
    last_d    = fault_vld ? fault_way : last_q;
    // both waiting: serve the one not reported most recently
    serve_way = (&pend_m) ? ~last_d : pend_m[1];
    pend_any  = |pend_m;
    pend_d    = take ? (pend_m & ~way_bit(serve_way)) : pend_m;
    upd_en    = fault_vld | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      last_q <= 1'b0;
    end else if (upd_en) begin
      pend_q <= pend_d;
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/tlb_wd_walker.sv
module tlb_wd_walker #(
  parameter  int ENTRIES = 64,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_way,
  output logic             busy,
  output logic             way,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic             busy_q, busy_d;
  logic             way_q, way_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             upd_en;

  always_comb begin
    busy_d = busy_q;
    way_d  = way_q;
    idx_d  = idx_q;
    if (start) begin
      busy_d = 1'b1;
      way_d  = start_way;
      idx_d  = '0;
    end else if (busy_q) begin
      if (idx_q == LAST_IDX) busy_d = 1'b0;
      else                   idx_d  = idx_q + 1'b1;
    end
    upd_en = start | busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      way_q  <= 1'b0;
      idx_q  <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      way_q  <= way_d;
      idx_q  <= idx_d;
    end
  end

  assign busy = busy_q;
  assign way  = way_q;
  assign idx  = idx_q;
  assign last = busy_q & (idx_q == LAST_IDX);
endmodule

// File: rtl/tlb_wd_way_state.sv
module tlb_wd_way_state
  import tlb_wd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      start_way,
  input  logic      err_clr,
  output way_mask_t active,
  output logic      err
);
  way_mask_t active_q, active_d;
  logic      err_q, err_d;
  logic      err_en;

  always_comb begin
    // named way goes off; any earlier-disabled way comes back
    active_d = start ? ~way_bit(start_way) : active_q;
    err_d    = start | (err_q & ~err_clr);
    err_en   = start | err_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= '1;
    else if (start) active_q <= active_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign active = active_q;
  assign err    = err_q;
endmodule

// File: rtl/tlb_way_degrade.sv
module tlb_way_degrade
  import tlb_wd_pkg::*;
#(
  parameter  int ENTRIES = 64,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_vld,
  input  logic             fault_way,
  input  logic             err_clr,
  output logic [1:0]       way_active,
  output logic [1:0]       refill_allow,
  output logic             inv_busy,
  output logic             inv_way,
  output logic [IDX_W-1:0] inv_idx,
  output logic             err_flag
);
  logic      rst_sync_n;
  logic      pend_any, serve_way;
  logic      walk_last, take;
  way_mask_t active;

  tlb_wd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tlb_wd_fault_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fault_vld (fault_vld),
    .fault_way (fault_way),
    .take      (take),
    .pend_any  (pend_any),
    .serve_way (serve_way)
  );

  // a new walk may begin when idle or on the last index of the current one
  assign take = pend_any & (~inv_busy | walk_last);

  tlb_wd_walker #(.ENTRIES(ENTRIES)) u_walk (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (take),
    .start_way (serve_way),
    .busy      (inv_busy),
    .way       (inv_way),
    .idx       (inv_idx),
    .last      (walk_last)
  );

  tlb_wd_way_state u_state (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (take),
    .start_way (serve_way),
    .err_clr   (err_clr),
    .active    (active),
    .err       (err_flag)
  );

  assign way_active   = active;
  assign refill_allow = inv_busy ? 2'b00 : active;
endmodule

// File: rtl/tlb_way_degrade_chk.sv
module tlb_way_degrade_chk #(
  parameter  int ENTRIES = 64,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fault_vld,
  input logic             fault_way,
  input logic             err_clr,
  input logic [1:0]       way_active,
  input logic [1:0]       refill_allow,
  input logic             inv_busy,
  input logic             inv_way,
  input logic [IDX_W-1:0] inv_idx,
  input logic             err_flag
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  assert_fault_idle_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vld && !inv_busy) |=> (inv_busy && inv_idx == '0 && inv_way == $past(fault_way)));

  assert_walk_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_busy && inv_idx != LAST_IDX) |=>
      (inv_busy && inv_idx == $past(inv_idx) + 1'b1 && inv_way == $past(inv_way)));

  assert_walk_way_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    inv_busy |-> !way_active[inv_way]);

  assert_never_both_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    way_active != 2'b00);

  assert_mask_moves_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(way_active) |-> (inv_busy && inv_idx == '0));

  assert_refill_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_busy |-> refill_allow == 2'b00);

  assert_err_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_busy && inv_idx == '0) |-> err_flag);

  assert_err_fall_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_flag) |-> $past(err_clr));
endmodule

bind tlb_way_degrade tlb_way_degrade_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .fault_vld    (fault_vld),
  .fault_way    (fault_way),
  .err_clr      (err_clr),
  .way_active   (way_active),
  .refill_allow (refill_allow),
  .inv_busy     (inv_busy),
  .inv_way      (inv_way),
  .inv_idx      (inv_idx),
  .err_flag     (err_flag)
);

// File: tb/tlb_way_degrade_test.sv
`timescale 1ns/1ps
module tlb_way_degrade_test;
  localparam int N  = 16;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          fault_vld, fault_way, err_clr;
  logic [1:0]    way_active, refill_allow;
  logic          inv_busy, inv_way, err_flag;
  logic [IW-1:0] inv_idx;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  tlb_way_degrade #(.ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .fault_vld(fault_vld), .fault_way(fault_way),
    .err_clr(err_clr), .way_active(way_active), .refill_allow(refill_allow),
    .inv_busy(inv_busy), .inv_way(inv_way), .inv_idx(inv_idx), .err_flag(err_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int       q[$];
  bit       m_busy;
  int       m_idx, m_way;
  bit [1:0] m_act;
  bit       m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_busy = 0; m_idx = 0; m_way = 0; m_act = 2'b11; m_err = 0;
    end else begin
      bit can_start;
      bit started;
      started = 0;
      if (fault_vld) begin
        for (int i = q.size() - 1; i >= 0; i--) if (q[i] == int'(fault_way)) q.delete(i);
        q.push_back(int'(fault_way));
      end
      can_start = !m_busy || (m_idx == N - 1);
      if (can_start && q.size() > 0) begin
        m_way   = q.pop_front();
        m_busy  = 1;
        m_idx   = 0;
        m_act   = 2'b11 & ~(2'b01 << m_way);
        m_err   = 1;
        started = 1;
      end else if (m_busy) begin
        if (m_idx == N - 1) m_busy = 0;
        else                m_idx++;
      end
      if (err_clr && !started) m_err = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(way_active == m_act, "R3 way_active", way_active, m_act);
      check(inv_busy == m_busy, "R4 inv_busy", inv_busy, m_busy);
      if (m_busy) begin
        check(int'(inv_idx) == m_idx, "R4 inv_idx", inv_idx, m_idx);
        check(int'(inv_way) == m_way, "R4 inv_way", inv_way, m_way);
      end
      check(refill_allow == (m_busy ? 2'b00 : m_act), "R5 refill_allow",
            refill_allow, m_busy ? 0 : m_act);
      check(err_flag == m_err, "R6 err_flag", err_flag, m_err);
    end
  end

  // entry array stub
  bit valid [2][N];
  bit fill_req;
  always @(posedge clk) begin
    if (fill_req) begin
      for (int w = 0; w < 2; w++) for (int i = 0; i < N; i++) valid[w][i] = 1'b1;
    end else if (inv_busy) begin
      valid[inv_way][inv_idx] = 1'b0;
    end
  end

  // length of the most recent unbroken busy run
  int run_len = 0, last_run = 0;
  always @(negedge clk) begin
    if (inv_busy) run_len++;
    else begin
      if (run_len != 0) last_run = run_len;
      run_len = 0;
    end
  end

  task automatic fill();
    fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
  endtask

  task automatic pulse(input bit w);
    fault_vld = 1'b1;
    fault_way = w;
    @(negedge clk);
    fault_vld = 1'b0;
  endtask

  task automatic check_stub(input int dead_way, input string req);
    int dead_left, live_left;
    dead_left = 0; live_left = 0;
    for (int i = 0; i < N; i++) begin
      dead_left += valid[dead_way][i];
      live_left += valid[1 - dead_way][i];
    end
    check(dead_left == 0, req, dead_left, 0);
    check(live_left == N, req, live_left, N);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; fault_vld = 1'b0; fault_way = 1'b0; err_clr = 1'b0; fill_req = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(way_active == 2'b11, "R1 way_active", way_active, 3);
    check(refill_allow == 2'b11, "R1 refill_allow", refill_allow, 3);
    check(!inv_busy, "R1 inv_busy", inv_busy, 0);
    check(!err_flag, "R1 err_flag", err_flag, 0);

    // R2 first reduction on way 0
    fill();
    pulse(1'b0);
    check(inv_busy && refill_allow == 2'b00, "R5 blocked during walk", refill_allow, 0);
    repeat (N + 3) @(negedge clk);
    check(way_active == 2'b10, "R2 way0 off", way_active, 2);
    check(err_flag, "R6 flag after reduction", err_flag, 1);
    check(last_run == N, "R4 walk length", last_run, N);
    check_stub(0, "R4 way0 entries cleared");

    // R3 fault on the last enabled way swaps ways
    fill();
    pulse(1'b1);
    repeat (N + 3) @(negedge clk);
    check(way_active == 2'b01, "R3 swap", way_active, 1);
    check_stub(1, "R4 way1 entries cleared");

    // R10 fault on the already disabled way
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    check(!err_flag, "R7 clear", err_flag, 0);
    pulse(1'b1);
    repeat (N + 3) @(negedge clk);
    check(way_active == 2'b01, "R10 mask kept", way_active, 1);
    check(last_run == N, "R10 full walk", last_run, N);
    check(err_flag, "R10 flag set", err_flag, 1);

    // R7 clear and walk start on the same edge
    err_clr = 1'b1;
    pulse(1'b0);
    err_clr = 1'b0;
    check(err_flag, "R7 start wins over clear", err_flag, 1);
    repeat (N + 3) @(negedge clk);
    check(way_active == 2'b10, "R2 way0 off again", way_active, 2);

    // R8 report held during a walk, back-to-back service
    pulse(1'b1);
    repeat (2) @(negedge clk);
    pulse(1'b0);
    repeat (2 * N + 4) @(negedge clk);
    check(last_run == 2 * N, "R8 no gap between walks", last_run, 2 * N);
    check(way_active == 2'b10, "R8 final mask", way_active, 2);

    // R9 ordering and merge of pending reports
    pulse(1'b0);
    pulse(1'b1);
    pulse(1'b0);
    repeat (3 * N + 4) @(negedge clk);
    check(last_run == 3 * N, "R9 merged walks", last_run, 3 * N);
    check(way_active == 2'b10, "R9 latest served last", way_active, 2);

    finish_run();
  end
endmodule